// File: doc/BRIEF.md
# DDR2 Read Latency Scheduler

This block sits in a DDR2-style memory controller. It tracks, cycle by cycle, when read data is due back from the memory after each READ command. A mode register image is written through a small write port together with a posted additive latency. The block takes the CAS latency from a three-bit field of that image and adds the additive latency to it. For every accepted READ it then raises a data-valid window that covers the four beats of the burst, and it tags each beat with its position in the burst.

Pending reads travel down a launch pipeline, one stage per clock. Several reads can be in flight at once, and reads issued one burst apart give an unbroken data window. Reserved latency codes and out-of-range additive latencies raise a configuration error, and READ commands are refused while that error is raised. A mode write that arrives while a read is in flight is dropped and leaves a sticky violation flag. The block models only cycle timing; strobe capture and phase alignment are handled elsewhere.

Top module: `rdlat_sched`

## Requirements
- R1: A synchronous active-low reset clears all pending reads and drives data_valid low, cfg_err low and mr_viol low. It leaves a total read latency of 3 (CAS latency 3, additive latency 0).
- R2: The CAS latency is taken from bits 6:4 of the mode image, and the other image bits have no effect. Codes 011, 100, 101, 110 and 111 give 3, 4, 5, 6 and 7 cycles. With additive latency 0, a READ sampled at clock edge n makes data_valid high from edge n+CL.
- R3: The additive latency (0 to 4) is captured with the mode write. The first beat then starts at edge n+AL+CL, including the extreme case AL=4, CL=7.
- R4: An accepted mode write with a reserved latency code (000, 001 or 010) sets cfg_err. A later accepted legal write clears it.
- R5: An accepted mode write with an additive latency above 4 sets cfg_err.
- R6: While cfg_err is high, a READ command produces no data window.
- R7: Each burst holds data_valid high for exactly four consecutive cycles, with beat_idx 0, 1, 2, 3 in that order. data_valid then drops unless another burst follows.
- R8: READs issued exactly four cycles apart produce one continuous data_valid window, with beat_idx repeating 0 to 3 once per read.
- R9: A mode write is ignored, leaving the latency and cfg_err unchanged, when any read is pending. This covers a read in the launch pipeline, a data window in progress, and a READ accepted in the same cycle as the write. At all other times a mode write is applied.
- R10: An ignored mode write sets mr_viol. mr_viol stays high through later accepted writes until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mr_wr_en | input | 1 | Mode image write strobe |
| mr_wr_data | input | MR_W | Mode image; CAS latency code in bits 6:4 |
| al_set | input | AL_W | Additive latency captured with the mode write |
| rd_cmd | input | 1 | One-cycle READ command pulse |
| data_valid | output | 1 | High during each expected data beat |
| beat_idx | output | BEAT_W | Beat index within the burst |
| cfg_err | output | 1 | Current configuration is illegal |
| mr_viol | output | 1 | Sticky flag: a mode write was dropped |

## Verification
Two things can land in the same clock: a mode write and an accepted READ. Reconfiguration and scheduling then compete for the same edge. The bench drives both strobes in one cycle, and also drives a write while a read is still in the launch pipeline and while a data window is under way. It judges each case at the ports. mr_viol must rise, and a later read must still use the old latency. The bench also drives a READ together with a write while the configuration is in error. That READ is refused, so the write must be applied and no violation recorded.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;
   // Position and width of the CAS latency field inside the mode image
   localparam int CL_LSB = 4;
   localparam int CL_W   = 3;
   // Code values equal the latency in cycles; below this code is reserved
   localparam logic [CL_W-1:0] CL_CODE_MIN = 3'd3;
   localparam int CL_MAX = 7;
   localparam int CL_MIN = 3;
endpackage

// File: rtl/rdlat_mode_reg.sv
module rdlat_mode_reg
   import rdlat_pkg::*;
#(
   parameter int AL_W   = 3,
   parameter int AL_MAX = 4,
   parameter int LAT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CL_W-1:0]  cl_code,
   input  logic [AL_W-1:0]  al_in,
   input  logic             busy,
   output logic [LAT_W-1:0] lat_m1,
   output logic             cfg_err,
   output logic             mr_viol
);
   logic cl_bad, al_bad, wr_ok;

   assign cl_bad = (cl_code < CL_CODE_MIN);
   assign al_bad = (al_in > AL_W'(AL_MAX));
   assign wr_ok  = wr_en & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_m1  <= LAT_W'(CL_MIN - 1);
         cfg_err <= 1'b0;
         mr_viol <= 1'b0;
      end else begin
         if (wr_ok) begin
            lat_m1  <= LAT_W'(al_in) + LAT_W'(cl_code) - LAT_W'(1);
            cfg_err <= cl_bad | al_bad;
         end
         if (wr_en && busy)
            mr_viol <= 1'b1;
      end
   end

   // R9: a write during a pending read leaves the configuration untouched
   a_r9_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> ($stable(lat_m1) && $stable(cfg_err)));
   // R10: a dropped write is flagged
   a_r10_viol_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> mr_viol);
   // R10: the flag is sticky until reset
   a_r10_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      mr_viol |=> mr_viol);
   // R4: a reserved code that is accepted leaves the error raised
   a_r4_reserved_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && (cl_code < CL_CODE_MIN)) |=> cfg_err);
endmodule

// File: rtl/rdlat_launch_pipe.sv
module rdlat_launch_pipe #(
   parameter int DEPTH = 11,
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LAT_W-1:0] lat_m1,
   output logic             head,
   output logic             pending
);
   logic [DEPTH-1:0] stage_q;
   logic [DEPTH-1:0] stage_d;

   // Stage i means "burst starts i+1 edges from now"; a read enters at stage L-1
   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic hit;
      assign hit = load && (lat_m1 == LAT_W'(i));
      if (i == DEPTH - 1) begin : g_top
         assign stage_d[i] = hit;
      end else begin : g_mid
         assign stage_d[i] = stage_q[i+1] | hit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= stage_d;
   end

   assign head    = stage_q[0];
   assign pending = |stage_q;

   // R3: a pending read is never lost: a stage above zero moves down one place
   a_r3_stage_advances: assert property (@(posedge clk) disable iff (!rst_n)
      stage_q[1] |=> stage_q[0]);
endmodule

// File: rtl/rdlat_beat_gen.sv
module rdlat_beat_gen #(
   parameter int BURST_LEN = 4,
   parameter int BEAT_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              dv,
   output logic [BEAT_W-1:0] beat
);
   localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dv   <= 1'b0;
         beat <= '0;
      end else if (start) begin
         dv   <= 1'b1;
         beat <= '0;
      end else if (dv) begin
         if (beat == LAST) begin
            dv   <= 1'b0;
            beat <= '0;
         end else begin
            beat <= beat + BEAT_W'(1);
         end
      end
   end

   // R7: within a burst the index climbs by one each cycle
   a_r7_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dv && beat != LAST && !start) |=> (dv && beat == $past(beat) + BEAT_W'(1)));
   // R7: a window closes only after the last beat
   a_r7_window_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dv) |-> ($past(beat) == LAST));
endmodule

// File: rtl/rdlat_sched.sv
module rdlat_sched
   import rdlat_pkg::*;
#(
   parameter int MR_W      = 13,
   parameter int AL_W      = 3,
   parameter int AL_MAX    = 4,
   parameter int BURST_LEN = 4,
   localparam int BEAT_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1,
   localparam int DEPTH    = AL_MAX + CL_MAX,
   localparam int LAT_W    = $clog2((1 << AL_W) + CL_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mr_wr_en,
   input  logic [MR_W-1:0]   mr_wr_data,
   input  logic [AL_W-1:0]   al_set,
   input  logic              rd_cmd,
   output logic              data_valid,
   output logic [BEAT_W-1:0] beat_idx,
   output logic              cfg_err,
   output logic              mr_viol
);
   if (MR_W <= CL_LSB + CL_W) begin : g_chk_mr
      $error("MR_W must exceed the latency field");
   end
   if (AL_MAX >= (1 << AL_W)) begin : g_chk_al
      $error("AL_MAX does not fit in AL_W bits");
   end
   if (BURST_LEN < 2) begin : g_chk_bl
      $error("BURST_LEN must be at least 2");
   end

   logic [LAT_W-1:0] lat_m1;
   logic             rd_accept, busy, head, pending;
   logic [CL_W-1:0]  cl_code;
   logic             unused_mr_bits;

   assign cl_code        = mr_wr_data[CL_LSB +: CL_W];
   assign unused_mr_bits = ^{mr_wr_data[MR_W-1:CL_LSB+CL_W], mr_wr_data[CL_LSB-1:0]};
   assign rd_accept      = rd_cmd & ~cfg_err;
   assign busy           = pending | data_valid | rd_accept;

   rdlat_mode_reg #(.AL_W(AL_W), .AL_MAX(AL_MAX), .LAT_W(LAT_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .wr_en(mr_wr_en), .cl_code(cl_code),
      .al_in(al_set), .busy(busy), .lat_m1(lat_m1),
      .cfg_err(cfg_err), .mr_viol(mr_viol));

   rdlat_launch_pipe #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_pipe (
      .clk(clk), .rst_n(rst_n), .load(rd_accept), .lat_m1(lat_m1),
      .head(head), .pending(pending));

   rdlat_beat_gen #(.BURST_LEN(BURST_LEN), .BEAT_W(BEAT_W)) u_beat (
      .clk(clk), .rst_n(rst_n), .start(head),
      .dv(data_valid), .beat(beat_idx));

   // R6: with the error raised and nothing in flight, nothing gets scheduled
   a_r6_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !pending) |=> !pending);
   // R2: a window opens only when a launch reaches the head of the pipeline
   a_r2_window_from_head: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_valid) |-> $past(head));
endmodule

// File: tb/rdlat_sched_bench.sv
module rdlat_sched_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mr_wr_en = 1'b0;
   logic [12:0] mr_wr_data = '0;
   logic [2:0] al_set = '0;
   logic       rd_cmd = 1'b0;
   logic       data_valid;
   logic [1:0] beat_idx;
   logic       cfg_err;
   logic       mr_viol;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   rdlat_sched u_rdlat_sched (
      .clk(clk), .rst_n(rst_n), .mr_wr_en(mr_wr_en), .mr_wr_data(mr_wr_data),
      .al_set(al_set), .rd_cmd(rd_cmd), .data_valid(data_valid),
      .beat_idx(beat_idx), .cfg_err(cfg_err), .mr_viol(mr_viol));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [12:0] image(input int code);
      logic [12:0] m = 13'h1A8F;           // unrelated bits set on purpose (R2)
      m[6:4] = code[2:0];
      return m;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Write the mode image; call at a negedge, returns at the next negedge
   task automatic mr_write(input int code, input int al, input bit with_rd);
      mr_wr_en   = 1'b1;
      mr_wr_data = image(code);
      al_set     = al[2:0];
      rd_cmd     = with_rd;
      @(posedge clk);
      @(negedge clk);
      mr_wr_en = 1'b0;
      rd_cmd   = 1'b0;
   endtask

   // Issue n reads four cycles apart from an idle state and check the window
   task automatic run_reads(input int n, input int lat, input bit none, input string req);
      int bad = 0;
      int act = 0;
      int exp = 0;
      for (int k = 0; k < lat + 4 * n + 3; k++) begin
         rd_cmd = ((k % 4) == 0) && ((k / 4) < n);
         @(posedge clk);
         @(negedge clk);
         rd_cmd = 1'b0;
         begin
            bit edv = !none && (k >= lat) && (k < lat + 4 * n);
            int eb  = edv ? (k - lat) % 4 : 0;
            if (data_valid !== edv || (edv && beat_idx !== eb[1:0])) begin
               if (bad == 0) begin
                  act = {data_valid, beat_idx} ;
                  exp = {edv, eb[1:0]};
               end
               bad++;
            end
         end
      end
      chk(bad == 0, req, $sformatf("window for latency %0d ({dv,beat} at first mismatch)", lat),
          act, exp);
   endtask

   task automatic t_reset();
      do_reset();
      chk(data_valid == 1'b0, "R1", "data_valid after reset", data_valid, 0);
      chk(cfg_err == 1'b0, "R1", "cfg_err after reset", cfg_err, 0);
      chk(mr_viol == 1'b0, "R1", "mr_viol after reset", mr_viol, 0);
      run_reads(1, 3, 1'b0, "R1 R7");
   endtask

   task automatic t_cl_sweep();
      for (int c = 3; c <= 7; c++) begin
         mr_write(c, 0, 1'b0);
         chk(cfg_err == 1'b0, "R2", "cfg_err legal code", cfg_err, 0);
         run_reads(1, c, 1'b0, "R2 R7");
      end
   endtask

   task automatic t_al_sweep();
      for (int a = 1; a <= 4; a++) begin
         mr_write(3, a, 1'b0);
         run_reads(1, 3 + a, 1'b0, "R3");
      end
      mr_write(7, 4, 1'b0);
      run_reads(1, 11, 1'b0, "R3 max latency");
   endtask

   task automatic t_reserved();
      for (int c = 0; c <= 2; c++) begin
         mr_write(c, 0, 1'b0);
         chk(cfg_err == 1'b1, "R4", $sformatf("cfg_err reserved code %0d", c), cfg_err, 1);
         run_reads(1, 3, 1'b1, "R6");
      end
      // READ and write together while in error: READ refused, so write applies
      mr_write(4, 0, 1'b1);
      chk(cfg_err == 1'b0, "R4", "legal write clears cfg_err", cfg_err, 0);
      chk(mr_viol == 1'b0, "R9", "refused read does not block write", mr_viol, 0);
      run_reads(1, 4, 1'b0, "R9 write applied");
   endtask

   task automatic t_al_illegal();
      mr_write(3, 5, 1'b0);
      chk(cfg_err == 1'b1, "R5", "cfg_err AL=5", cfg_err, 1);
      run_reads(1, 3, 1'b1, "R6 AL error");
      mr_write(3, 7, 1'b0);
      chk(cfg_err == 1'b1, "R5", "cfg_err AL=7", cfg_err, 1);
      mr_write(4, 4, 1'b0);
      chk(cfg_err == 1'b0, "R5", "cfg_err AL=4 legal", cfg_err, 0);
      run_reads(1, 8, 1'b0, "R3 AL=4");
   endtask

   task automatic t_back_to_back();
      mr_write(5, 2, 1'b0);
      run_reads(3, 7, 1'b0, "R8");
      mr_write(3, 0, 1'b0);
      run_reads(2, 3, 1'b0, "R8 min latency");
   endtask

   task automatic t_write_busy();
      mr_write(4, 0, 1'b0);
      // write while the read is still in the launch pipeline
      rd_cmd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_cmd = 1'b0;
      @(negedge clk);
      mr_write(7, 0, 1'b0);
      repeat (10) @(negedge clk);
      chk(mr_viol == 1'b1, "R10", "mr_viol after write in pipeline", mr_viol, 1);
      run_reads(1, 4, 1'b0, "R9 pipeline write dropped");
      // write during the data window
      rd_cmd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_cmd = 1'b0;
      repeat (4) @(negedge clk);
      chk(data_valid == 1'b1, "R9", "window under way before write", data_valid, 1);
      mr_write(6, 0, 1'b0);
      repeat (8) @(negedge clk);
      run_reads(1, 4, 1'b0, "R9 window write dropped");
      // an idle write is still applied, and the flag stays
      mr_write(5, 1, 1'b0);
      run_reads(1, 6, 1'b0, "R9 idle write applied");
      chk(mr_viol == 1'b1, "R10", "mr_viol sticky", mr_viol, 1);
   endtask

   task automatic t_same_cycle();
      do_reset();
      chk(mr_viol == 1'b0, "R10", "reset clears mr_viol", mr_viol, 0);
      mr_write(7, 2, 1'b1);
      repeat (10) @(negedge clk);
      chk(mr_viol == 1'b1, "R10", "mr_viol same-cycle write", mr_viol, 1);
      run_reads(1, 3, 1'b0, "R9 same-cycle write dropped");
   endtask

   initial begin
      while (1) begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      t_reset();
      t_cl_sweep();
      t_al_sweep();
      t_reserved();
      t_al_illegal();
      t_back_to_back();
      t_write_busy();
      t_same_cycle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule